// File: doc/BRIEF.md
# Hypervisor Interrupt Maintenance Controller

This block holds the hypervisor-side control state of a virtualised interrupt controller for up to eight virtual CPUs. Each CPU has its own bank. A bank holds a control word, a packed virtual-machine control word and a small set of list entries. From the live list entries and the enable bits, each bank derives three things: a bitmap of entries waiting for an end-of-interrupt notification, a bitmap of empty entries, and an eight-bit maintenance status word. Each bank drives one level-sensitive maintenance interrupt.

Software reaches the banks through separate 32-bit read and write ports. The low 9 address bits select a register. The bits above them select the bank. A slice index of zero means the bank of the requesting CPU. A nonzero index names a CPU bank directly. Read data is registered and is returned in the cycle after the read request.

Top module: `hyp_maint_ctrl`

## Requirements
- R1: After reset, every maintenance interrupt is low. The control, VM-control, status and list registers read 0. The empty-entry map reads all ones for the implemented entries (0xF with four entries).
- R2: Bank selection uses the address bits at position 9 and above. A value of 0 selects the bank of `req_cpu`, and values 1 to NCPU-1 select that CPU's bank. A higher value raises `bus_err` and changes no state.
- R3: The type register at offset 0x004 reads 0x44000000 OR (NLR-1), which is 0x44000003 with the defaults.
- R4: The VM-control register at offset 0x008 keeps the bits of mask 0xF8FC021F and reads the other bits as 0. Group-0 enable is bit 0 and group-1 enable is bit 1.
- R5: The control register at offset 0x000 keeps the bits of mask 0xF80000FF. Its fields are:
  - enable at bit 0;
  - underflow, entry-not-present and no-pending enables at bits 1, 2 and 3;
  - group-0-enabled at bit 4 and group-0-disabled at bit 5;
  - group-1-enabled at bit 6 and group-1-disabled at bit 7;
  - EOI count at bits 31:27.
- R6: List entry i is a full 32-bit word at offset 0x100+4i. Its state field is bits 29:28, where 0 means invalid and bit 28 set means pending. Its EOI-notify flag is bit 19.
- R7: The EOI map at offset 0x020 has bit i set when entry i is invalid and its EOI-notify flag is set. Offset 0x024 holds entries 32 and above and reads 0 with four entries.
- R8: The empty map at offset 0x030 has bit i set when entry i's state is 0. Offset 0x034 covers entries 32 and above.
- R9: The status word at offset 0x010 is built from the control enables and the VM-control group enables:
  - bit 7 is group-1-disabled AND NOT group-1 enable;
  - bit 6 is group-1-enabled AND group-1 enable;
  - bit 5 is group-0-disabled AND NOT group-0 enable;
  - bit 4 is group-0-enabled AND group-0 enable.
- R10: The lower status bits are built from the list entries:
  - bit 3 is no-pending enable AND no entry pending;
  - bit 2 is entry-not-present enable AND a nonzero EOI count;
  - bit 1 is underflow enable AND at most one valid entry;
  - bit 0 is set when the EOI map is nonzero.
- R11: `maint_irq[c]` is high exactly when, in the previous cycle, bank c had its control enable set and a nonzero status word.
- R12: The active-priority register at offset 0x0F0 reads 0. Writes to it are ignored and raise no error.
- R13: `bus_err` pulses in the cycle after a read or write to an undefined or misaligned offset, or to a list index at or above NLR. Such a read returns 0 and such a write changes nothing.
- R14: `rd_valid` and `rd_data` follow `rd_en` by one cycle. The data reflects the state before any write accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cpu | input | 3 | CPU that issues the access (used when the slice index is 0) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 13 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 13 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| bus_err | output | 1 | Pulse flagging an access to an invalid offset or bank |
| maint_irq | output | 8 | Level maintenance interrupt, one per CPU |

## Verification
A read and a write can land on the same register in the same cycle. For example, a control word can be read in the very cycle it is written. The bench provokes this by raising both strobes with equal addresses. It expects the old value back, and the new value on the following read. A list-entry write can also change the status word and the interrupt level in the cycle in which software reads that status. The behavioural model computes the outputs from the pre-edge state before it applies the write, and it compares the interrupt vector, the error pulse and the read data every cycle.

// File: rtl/hmc_pkg.sv
package hmc_pkg;

  typedef enum logic [3:0] {
    RG_CTL,
    RG_TYPE,
    RG_VMC,
    RG_MST,
    RG_EOI_LO,
    RG_EOI_HI,
    RG_EMP_LO,
    RG_EMP_HI,
    RG_APR,
    RG_LIST,
    RG_BAD
  } hmc_reg_e;

  // Control word field positions
  localparam int CTL_EN     = 0;
  localparam int CTL_UNDER  = 1;
  localparam int CTL_NOENT  = 2;
  localparam int CTL_NOPEND = 3;
  localparam int CTL_G0_ON  = 4;
  localparam int CTL_G0_OFF = 5;
  localparam int CTL_G1_ON  = 6;
  localparam int CTL_G1_OFF = 7;
  localparam int CTL_CNT_LO = 27;

  // VM control group enables
  localparam int VMC_G0 = 0;
  localparam int VMC_G1 = 1;

  // List entry fields
  localparam int LST_ST_LO = 28;
  localparam int LST_EOI   = 19;

  localparam logic [31:0] CTL_MASK = 32'hF800_00FF;
  localparam logic [31:0] VMC_MASK = 32'hF8FC_021F;
  localparam logic [31:0] TYPE_TAG = 32'h4400_0000;

endpackage

// File: rtl/hmc_addr_decode.sv
module hmc_addr_decode
  import hmc_pkg::*;
#(
  parameter int NCPU   = 8,
  parameter int NLR    = 4,
  parameter int ADDR_W = 13,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int LR_W  = (NLR > 1) ? $clog2(NLR) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic [CPU_W-1:0]  bank,
  output hmc_reg_e          kind,
  output logic [LR_W-1:0]   lr_idx
);

  localparam int SLICE_W = ADDR_W - 9;

  logic [SLICE_W-1:0] slice;
  logic [8:0]         off;
  logic               slice_ok;

  always_comb begin
    slice    = addr[ADDR_W-1:9];
    off      = addr[8:0];
    bank     = req_cpu;
    kind     = RG_BAD;
    lr_idx   = '0;
    slice_ok = 1'b1;
    if (slice != '0) begin
      if (int'(slice) < NCPU) bank = slice[CPU_W-1:0];
      else                    slice_ok = 1'b0;
    end
    if (slice_ok) begin
      case (off)
        9'h000:  kind = RG_CTL;
        9'h004:  kind = RG_TYPE;
        9'h008:  kind = RG_VMC;
        9'h010:  kind = RG_MST;
        9'h020:  kind = RG_EOI_LO;
        9'h024:  kind = RG_EOI_HI;
        9'h030:  kind = RG_EMP_LO;
        9'h034:  kind = RG_EMP_HI;
        9'h0F0:  kind = RG_APR;
        default: begin
          if (off[8] && (off[1:0] == 2'b00) && (int'(off[7:2]) < NLR)) begin
            kind   = RG_LIST;
            lr_idx = off[2 +: LR_W];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/hmc_cpu_bank.sv
module hmc_cpu_bank
  import hmc_pkg::*;
#(
  parameter int NLR = 4,
  localparam int LR_W = (NLR > 1) ? $clog2(NLR) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_hit,
  input  hmc_reg_e              wr_kind,
  input  logic [LR_W-1:0]       wr_lr,
  input  logic [31:0]           wr_data,
  output logic [31:0]           ctl_q,
  output logic [31:0]           vmc_q,
  output logic [NLR-1:0][31:0]  lr_q,
  output logic [NLR-1:0]        eoi_map,
  output logic [NLR-1:0]        emp_map,
  output logic [7:0]            mst,
  output logic                  irq_q
);

  logic [NLR-1:0] pend_v;
  logic           few_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      vmc_q <= '0;
    end else if (wr_hit) begin
      case (wr_kind)
        RG_CTL:  ctl_q <= wr_data & CTL_MASK;
        RG_VMC:  vmc_q <= wr_data & VMC_MASK;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NLR; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        lr_q[i] <= '0;
      else if (wr_hit && (wr_kind == RG_LIST) && (wr_lr == LR_W'(i)))
        lr_q[i] <= wr_data;
    end
    assign emp_map[i] = (lr_q[i][LST_ST_LO +: 2] == 2'b00);
    assign eoi_map[i] = emp_map[i] & lr_q[i][LST_EOI];
    assign pend_v[i]  = lr_q[i][LST_ST_LO];
  end

  assign few_valid = ($countones(~emp_map) <= 1);

  assign mst[7] = ctl_q[CTL_G1_OFF] & ~vmc_q[VMC_G1];
  assign mst[6] = ctl_q[CTL_G1_ON]  &  vmc_q[VMC_G1];
  assign mst[5] = ctl_q[CTL_G0_OFF] & ~vmc_q[VMC_G0];
  assign mst[4] = ctl_q[CTL_G0_ON]  &  vmc_q[VMC_G0];
  assign mst[3] = ctl_q[CTL_NOPEND] & ~(|pend_v);
  assign mst[2] = ctl_q[CTL_NOENT]  & (|ctl_q[31:CTL_CNT_LO]);
  assign mst[1] = ctl_q[CTL_UNDER]  & few_valid;
  assign mst[0] = |eoi_map;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ctl_q[CTL_EN] & (|mst);
  end

endmodule

// File: rtl/hyp_maint_ctrl.sv
module hyp_maint_ctrl
  import hmc_pkg::*;
#(
  parameter int NCPU   = 8,
  parameter int NLR    = 4,
  parameter int ADDR_W = 13,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int LR_W  = (NLR > 1) ? $clog2(NLR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              bus_err,
  output logic [NCPU-1:0]   maint_irq
);

  localparam int MAP_W = 64;

  logic [CPU_W-1:0] rd_bank, wr_bank;
  hmc_reg_e         rd_kind, wr_kind;
  logic [LR_W-1:0]  rd_lr, wr_lr;

  logic [31:0]          ctl_a [NCPU];
  logic [31:0]          vmc_a [NCPU];
  logic [NLR-1:0][31:0] lr_a  [NCPU];
  logic [NLR-1:0]       eoi_a [NCPU];
  logic [NLR-1:0]       emp_a [NCPU];
  logic [MAP_W-1:0]     eoi_pad [NCPU];
  logic [MAP_W-1:0]     emp_pad [NCPU];
  logic [7:0]           mst_a [NCPU];
  logic [NCPU-1:0]      wr_hit_v, irq_v, en_v, mst_nz_v;
  logic [31:0]          rd_word;

  hmc_addr_decode #(.NCPU(NCPU), .NLR(NLR), .ADDR_W(ADDR_W)) u_rd_dec (
    .addr(rd_addr), .req_cpu(req_cpu), .bank(rd_bank), .kind(rd_kind), .lr_idx(rd_lr)
  );

  hmc_addr_decode #(.NCPU(NCPU), .NLR(NLR), .ADDR_W(ADDR_W)) u_wr_dec (
    .addr(wr_addr), .req_cpu(req_cpu), .bank(wr_bank), .kind(wr_kind), .lr_idx(wr_lr)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_bank
    assign wr_hit_v[c] = wr_en && (wr_kind != RG_BAD) && (wr_bank == CPU_W'(c));

    hmc_cpu_bank #(.NLR(NLR)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (wr_hit_v[c]),
      .wr_kind (wr_kind),
      .wr_lr   (wr_lr),
      .wr_data (wr_data),
      .ctl_q   (ctl_a[c]),
      .vmc_q   (vmc_a[c]),
      .lr_q    (lr_a[c]),
      .eoi_map (eoi_a[c]),
      .emp_map (emp_a[c]),
      .mst     (mst_a[c]),
      .irq_q   (irq_v[c])
    );

    assign eoi_pad[c]  = MAP_W'(eoi_a[c]);
    assign emp_pad[c]  = MAP_W'(emp_a[c]);
    assign en_v[c]     = ctl_a[c][CTL_EN];
    assign mst_nz_v[c] = |mst_a[c];
  end

  always_comb begin
    case (rd_kind)
      RG_CTL:    rd_word = ctl_a[rd_bank];
      RG_TYPE:   rd_word = TYPE_TAG | 32'(NLR - 1);
      RG_VMC:    rd_word = vmc_a[rd_bank];
      RG_MST:    rd_word = {24'b0, mst_a[rd_bank]};
      RG_EOI_LO: rd_word = eoi_pad[rd_bank][31:0];
      RG_EOI_HI: rd_word = eoi_pad[rd_bank][63:32];
      RG_EMP_LO: rd_word = emp_pad[rd_bank][31:0];
      RG_EMP_HI: rd_word = emp_pad[rd_bank][63:32];
      RG_LIST:   rd_word = lr_a[rd_bank][rd_lr];
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      bus_err  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_word : '0;
      bus_err  <= (rd_en && (rd_kind == RG_BAD)) || (wr_en && (wr_kind == RG_BAD));
    end
  end

  assign maint_irq = irq_v;

endmodule

// File: rtl/hyp_maint_ctrl_chk.sv
module hyp_maint_ctrl_chk #(
  parameter int NCPU   = 8,
  parameter int NLR    = 4,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              rd_valid,
  input logic              bus_err,
  input logic [NCPU-1:0]   maint_irq,
  input logic [NCPU-1:0]   en_v,
  input logic [NCPU-1:0]   mst_nz_v
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (maint_irq == '0 && !rd_valid && !bus_err));

  // R14
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(rd_en)));

  // R13
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> ($past(rd_en) || $past(wr_en)));

  // R3
  type_value_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_addr[8:0]) == 9'h004 && int'($past(rd_addr[ADDR_W-1:9])) < NCPU)
      |-> (rd_data == (32'h4400_0000 | 32'(NLR - 1))));

  // R12
  apr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_addr[8:0]) == 9'h0F0) |-> (rd_data == 32'h0));

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (maint_irq == $past(en_v & mst_nz_v)));

endmodule

bind hyp_maint_ctrl hyp_maint_ctrl_chk #(.NCPU(NCPU), .NLR(NLR), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .bus_err   (bus_err),
  .maint_irq (maint_irq),
  .en_v      (en_v),
  .mst_nz_v  (mst_nz_v)
);

// File: tb/hyp_maint_ctrl_tb.sv
module hyp_maint_ctrl_tb;

  localparam int NCPU = 8;
  localparam int NLR  = 4;
  localparam int AW   = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    req_cpu = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          rd_valid;
  logic          bus_err;
  logic [NCPU-1:0] maint_irq;

  always #10 clk = ~clk;

  hyp_maint_ctrl #(.NCPU(NCPU), .NLR(NLR), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .req_cpu(req_cpu),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .bus_err(bus_err), .maint_irq(maint_irq)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Behavioural reference model
  logic [31:0] m_ctl [NCPU];
  logic [31:0] m_vmc [NCPU];
  logic [31:0] m_lr  [NCPU][NLR];
  logic [31:0] e_rd = '0;
  logic        e_valid = 1'b0;
  logic        e_err = 1'b0;
  logic [NCPU-1:0] e_irq = '0;

  function automatic int bank_of(int cpu, int addr);
    int s = addr >> 9;
    if (s == 0) return cpu;
    if (s >= NCPU) return -1;
    return s;
  endfunction

  function automatic bit known(int off);
    if (off == 'h000 || off == 'h004 || off == 'h008 || off == 'h010) return 1;
    if (off == 'h020 || off == 'h024 || off == 'h030 || off == 'h034) return 1;
    if (off == 'h0F0) return 1;
    if (off >= 'h100 && off < 'h100 + 4*NLR && (off % 4) == 0) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] emp_of(int b);
    logic [31:0] r = '0;
    for (int i = 0; i < NLR; i++)
      if (((m_lr[b][i] >> 28) & 3) == 0) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] eoi_of(int b);
    logic [31:0] r = '0;
    for (int i = 0; i < NLR; i++)
      if (((m_lr[b][i] >> 28) & 3) == 0 && m_lr[b][i][19]) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] mst_of(int b);
    int nv = 0;
    bit pend = 0;
    logic [31:0] c = m_ctl[b];
    logic [31:0] v = m_vmc[b];
    logic [31:0] r = '0;
    for (int i = 0; i < NLR; i++) begin
      int st = int'((m_lr[b][i] >> 28) & 3);
      if (st != 0) nv++;
      if (st == 1 || st == 3) pend = 1;
    end
    if (c[7] && !v[1]) r = r | 32'h80;
    if (c[6] &&  v[1]) r = r | 32'h40;
    if (c[5] && !v[0]) r = r | 32'h20;
    if (c[4] &&  v[0]) r = r | 32'h10;
    if (c[3] && !pend) r = r | 32'h08;
    if (c[2] && (c >> 27) != 0) r = r | 32'h04;
    if (c[1] && nv <= 1) r = r | 32'h02;
    if (eoi_of(b) != 0) r = r | 32'h01;
    return r;
  endfunction

  function automatic logic [31:0] read_of(int b, int off);
    case (off)
      'h000: return m_ctl[b];
      'h004: return 32'h4400_0000 | (NLR - 1);
      'h008: return m_vmc[b];
      'h010: return mst_of(b);
      'h020: return eoi_of(b);
      'h030: return emp_of(b);
      'h024, 'h034, 'h0F0: return 0;
      default: return m_lr[b][(off - 'h100) / 4];
    endcase
  endfunction

  always @(posedge clk) begin
    logic [NCPU-1:0] nirq;
    int rb, wb, roff, woff;
    bit rok, wok;
    if (rst) begin
      for (int c = 0; c < NCPU; c++) begin
        m_ctl[c] = '0;
        m_vmc[c] = '0;
        for (int i = 0; i < NLR; i++) m_lr[c][i] = '0;
      end
      e_valid = 0; e_err = 0; e_irq = '0; e_rd = '0;
    end else begin
      for (int c = 0; c < NCPU; c++) nirq[c] = m_ctl[c][0] && (mst_of(c) != 0);
      rb   = bank_of(int'(req_cpu), int'(rd_addr));
      wb   = bank_of(int'(req_cpu), int'(wr_addr));
      roff = int'(rd_addr) & 'h1FF;
      woff = int'(wr_addr) & 'h1FF;
      rok  = rb >= 0 && known(roff);
      wok  = wb >= 0 && known(woff);
      e_valid = rd_en;
      e_rd    = (rd_en && rok) ? read_of(rb, roff) : '0;
      e_err   = (rd_en && !rok) || (wr_en && !wok);
      if (wr_en && wok) begin
        if (woff == 'h000) m_ctl[wb] = wr_data & 32'hF800_00FF;
        else if (woff == 'h008) m_vmc[wb] = wr_data & 32'hF8FC_021F;
        else if (woff >= 'h100) m_lr[wb][(woff - 'h100) / 4] = wr_data;
      end
      e_irq = nirq;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    checks++;
    if (maint_irq !== e_irq) begin
      fails++;
      $display("FAIL R11 maint_irq got %h expected %h", maint_irq, e_irq);
    end
    checks++;
    if (bus_err !== e_err) begin
      fails++;
      $display("FAIL R13 bus_err got %b expected %b", bus_err, e_err);
    end
    checks++;
    if (rd_valid !== e_valid || (e_valid && rd_data !== e_rd)) begin
      fails++;
      $display("FAIL R14 read got %b/%h expected %b/%h", rd_valid, rd_data, e_valid, e_rd);
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int cpu, input int addr, input logic [31:0] d);
    req_cpu = 3'(cpu); wr_addr = AW'(addr); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int cpu, input int addr, output logic [31:0] d, output logic e);
    req_cpu = 3'(cpu); rd_addr = AW'(addr); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    e = bus_err;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired, R1 to R14 sequence incomplete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(maint_irq), 0);
    rd(0, 'h000, d, e); chk("R1 ctl", d, 0);
    rd(0, 'h010, d, e); chk("R1 mst", d, 0);
    rd(0, 'h030, d, e); chk("R1 empty map", d, 32'hF);

    // R3 type register, banked and through a slice
    rd(5, 'h004, d, e); chk("R3 type", d, 32'h4400_0003);
    rd(0, 'h604, d, e); chk("R3 type slice", d, 32'h4400_0003);

    // R5 and R2: write banked, read via slice
    wr(2, 'h000, 32'hFFFF_FFFF);
    rd(0, 'h400, d, e); chk("R5 ctl mask", d, 32'hF800_00FF);
    chk("R11 irq cpu2", 32'(maint_irq[2]), 1);
    rd(2, 'h000, d, e); chk("R2 banked view", d, 32'hF800_00FF);

    // R4 VM control
    wr(0, 'h208, 32'hFFFF_FFFF);
    rd(0, 'h208, d, e); chk("R4 vmc mask", d, 32'hF8FC_021F);
    wr(1, 'h008, 32'h0);
    rd(0, 'h208, d, e); chk("R2 requester bank", d, 0);

    // R6 R7 R8 list entries of cpu3
    wr(0, 'h700, 32'h0008_0000);
    wr(0, 'h704, 32'h1000_0000);
    wr(0, 'h708, 32'h2008_0000);
    rd(0, 'h708, d, e); chk("R6 list entry", d, 32'h2008_0000);
    rd(0, 'h620, d, e); chk("R7 eoi map", d, 32'h1);
    rd(0, 'h624, d, e); chk("R7 eoi map hi", d, 0);
    rd(0, 'h630, d, e); chk("R8 empty map", d, 32'h9);
    rd(0, 'h634, d, e); chk("R8 empty map hi", d, 0);

    // R9 R10 status word
    wr(0, 'h600, 32'h0000_00FE);
    rd(0, 'h610, d, e); chk("R9 R10 mst", d, 32'hA1);
    chk("R11 irq off while disabled", 32'(maint_irq[3]), 0);
    wr(0, 'h608, 32'h3);
    rd(0, 'h610, d, e); chk("R9 group enables", d, 32'h51);
    wr(0, 'h600, 32'h0800_00FE);
    rd(0, 'h610, d, e); chk("R10 eoi count", d, 32'h55);
    wr(0, 'h704, 32'h0);
    rd(0, 'h610, d, e); chk("R10 no pending underflow", d, 32'h5F);

    // R11 interrupt level
    wr(0, 'h600, 32'h0800_00FF);
    rd(0, 'h610, d, e);
    chk("R11 irq raised", 32'(maint_irq[3]), 1);
    wr(0, 'h600, 32'h0000_0001);
    rd(0, 'h610, d, e); chk("R10 eoi only", d, 32'h01);
    chk("R11 irq held", 32'(maint_irq[3]), 1);
    wr(0, 'h700, 32'h0);
    rd(0, 'h610, d, e); chk("R10 cleared", d, 0);
    chk("R11 irq dropped", 32'(maint_irq[3]), 0);

    // R12 active priority
    wr(0, 'h0F0, 32'hFFFF_FFFF);
    chk("R12 no error on write", 32'(bus_err), 0);
    rd(0, 'h0F0, d, e); chk("R12 read zero", d, 0); chk("R12 no error", 32'(e), 0);

    // R13 bad offsets
    rd(0, 'h00C, d, e); chk("R13 undefined data", d, 0); chk("R13 undefined err", 32'(e), 1);
    rd(0, 'h102, d, e); chk("R13 misaligned err", 32'(e), 1);
    rd(0, 'h110, d, e); chk("R13 list index err", 32'(e), 1);
    wr(0, 'h00C, 32'hFFFF_FFFF);
    chk("R13 write err", 32'(bus_err), 1);

    // R2 slice out of range
    wr(0, 'h1000, 32'hFF);
    chk("R2 bad slice err", 32'(bus_err), 1);
    rd(0, 'h000, d, e); chk("R2 bad slice no change", d, 0);

    // R14 same-cycle read and write
    req_cpu = 3'd4; wr_addr = '0; wr_data = 32'h10; wr_en = 1'b1;
    rd_addr = '0; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R14 old value", rd_data, 0);
    rd(4, 'h000, d, e); chk("R14 new value", d, 32'h10);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule